// File: doc/BRIEF.md
# Pulse Accumulator with Status Flags

This block counts activity on a primary input pin. It keeps a 16-bit accumulator that can also be split into two independent 8-bit halves. In event mode, every selected edge on the primary pin adds one to the count. In gated mode, the block adds one for every cycle in which the clock enable is high while the primary pin is at its active level. The lower byte, or the whole 16-bit word, follows the primary pin. In split mode, the upper byte follows edges on a secondary pin.

Two sticky status flags record an overflow and a primary-pin edge event. Software clears them by writing ones through a small register port. A fast-clear option replaces the write-one clearing: any access to the count register then clears both flags. A maximum-hold option pins the upper byte at 0xFF. Each flag has an interrupt enable, and the interrupt request combines the enabled flags.

Both pins pass through a two-stage synchroniser. A changed pin value therefore reaches the count on the third rising clock edge after it is applied.

Top module: `pulse_accum`

## Requirements
- R1: With `acc_enable`=1, `gated_mode`=0 and `split_mode`=0, each selected primary edge adds one to the 16-bit count. `pri_rise`=1 selects rising edges and 0 selects falling edges. The count changes on the third rising clock edge after the pin changes.
- R2: With `gated_mode`=1, the count adds one in each cycle where `clk_en`=1 and the synchronised primary pin equals `pri_rise`, which is the gate's active level. With `clk_en`=0 the count does not change.
- R3: In the cascaded configuration, a primary count step from 0xFFFF produces 0x0000 and sets the overflow flag. The overflow flag is bit 0 of the flag register.
- R4: With `split_mode`=1, bits 7:0 count primary events and wrap from 0xFF to 0x00 without setting any flag. Bits 15:8 count selected secondary edges, where `sec_rise`=1 selects rising. A step of bits 15:8 from 0xFF to 0x00 sets the overflow flag. With `split_mode`=0, the secondary pin has no effect.
- R5: With `split_mode`=1 and `max_hold`=1, bits 15:8 stay at 0xFF. A further secondary edge at 0xFF sets the overflow flag.
- R6: The edge flag is bit 1 of the flag register. It is set by the selected primary edge in event mode, and by the gate's trailing edge (leaving the active level) in gated mode.
- R7: With `fast_clear`=0, writing the flag register (`reg_sel`=1) with a one in a flag bit clears that flag. A zero leaves it unchanged. A set in the same cycle wins over the clear.
- R8: With `fast_clear`=1, writing ones to the flag register clears nothing. A `reg_rd` or `reg_wr` cycle with `reg_sel`=0 clears both flags.
- R9: After reset, the count and both flags are zero. Reading the flag register returns zero in bits 15:2.
- R10: `irq` is (overflow AND `ie_ovf`) OR (edge AND `ie_edge`).
- R11: A write with `reg_sel`=0 loads `reg_wdata` into the count. With `acc_enable`=0, no pin activity changes the count or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Prescaled tick counted in gated mode |
| pin_pri | input | 1 | Primary pin (event or gate input) |
| pin_sec | input | 1 | Secondary pin (upper byte in split mode) |
| acc_enable | input | 1 | Accumulator enable |
| gated_mode | input | 1 | 1 = gated-time mode, 0 = event mode |
| pri_rise | input | 1 | Primary edge select or gate active level |
| sec_rise | input | 1 | Secondary edge select |
| split_mode | input | 1 | 1 = two 8-bit accumulators |
| max_hold | input | 1 | Hold the upper byte at 0xFF in split mode |
| fast_clear | input | 1 | Flags cleared by count register access |
| ie_ovf | input | 1 | Overflow interrupt enable |
| ie_edge | input | 1 | Edge interrupt enable |
| reg_sel | input | 1 | 0 = count register, 1 = flag register |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| count | output | 16 | Current accumulator value |
| flag_ovf | output | 1 | Overflow flag |
| flag_edge | output | 1 | Edge flag |
| irq | output | 1 | Interrupt request |

## Verification
The flags are sticky, so a wrong internal overflow or edge decision shows on `flag_ovf` or `flag_edge` by the third clock after the pin change that caused it. It stays visible until software clears it. A wrong carry or hold decision in the counter shows on `count` in that same cycle and persists, because nothing else rewrites the value. Races between a set and a write-one clear are arranged to land in the exact cycle of the counter update, so a reversed priority leaves a visibly cleared flag.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic {
    REG_COUNT = 1'b0,
    REG_FLAGS = 1'b1
  } reg_sel_e;

  // bit 0 = overflow, bit 1 = edge
  typedef struct packed {
    logic edg;
    logic ovf;
  } flags_t;

  // next value of a sticky flag: set beats clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/pacc_pin_sync.sv
module pacc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         split,
  input  logic         max_hold,
  input  logic         inc_lo,
  input  logic         inc_hi,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap_full,
  output logic         wrap_half,
  output logic         hold_hit
);
  localparam int H = W / 2;

  logic [W-1:0] cnt_n;
  logic [H-1:0] hi, lo;

  function automatic logic [H-1:0] step_half(input logic [H-1:0] v, input logic en, input logic hold);
    return (en && !hold) ? v + 1'b1 : v;
  endfunction

  assign hi = cnt[W-1:H];
  assign lo = cnt[H-1:0];

  assign wrap_full = !load && !split && inc_lo && (cnt == '1);
  assign wrap_half = !load && split && inc_hi && (hi == '1) && !max_hold;
  assign hold_hit  = !load && split && inc_hi && (hi == '1) && max_hold;

  always_comb begin
    if (load)
      cnt_n = load_val;
    else if (!split)
      cnt_n = inc_lo ? cnt + 1'b1 : cnt;
    else
      cnt_n = {step_half(hi, inc_hi, hold_hit), step_half(lo, inc_lo, 1'b0)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  // R3: full-width wrap lands on zero
  assert_full_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_full |=> (cnt == '0));
  // R5: held upper half stays at all ones
  assert_hold_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_hit |=> (cnt[W-1:H] == '1));
  // R4: in split mode lower half moves only on its own increment
  assert_split_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !load && !inc_lo) |=> $stable(cnt[H-1:0]));
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags
  import pacc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   set_ovf,
  input  logic   set_edge,
  input  logic   wr_flags,
  input  flags_t wr_mask,
  input  logic   fast_mode,
  input  logic   fast_hit,
  input  logic   ie_ovf,
  input  logic   ie_edge,
  output flags_t flags,
  output logic   irq
);
  logic clr_ovf, clr_edge;

  assign clr_ovf  = fast_mode ? fast_hit : (wr_flags && wr_mask.ovf);
  assign clr_edge = fast_mode ? fast_hit : (wr_flags && wr_mask.edg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags.ovf <= sticky_next(flags.ovf, set_ovf, clr_ovf);
      flags.edg <= sticky_next(flags.edg, set_edge, clr_edge);
    end
  end

  assign irq = (flags.ovf && ie_ovf) || (flags.edg && ie_edge);

  // R7: a set event always leaves the flag high
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf |=> flags.ovf);
  // R8: in fast mode flag writes cannot clear
  assert_fast_no_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_mode && !fast_hit) |=> (flags.edg || !$past(flags.edg)));
  // R3: overflow rises only after a set source
  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.ovf) |-> $past(set_ovf));
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             pin_pri,
  input  logic             pin_sec,
  input  logic             acc_enable,
  input  logic             gated_mode,
  input  logic             pri_rise,
  input  logic             sec_rise,
  input  logic             split_mode,
  input  logic             max_hold,
  input  logic             fast_clear,
  input  logic             ie_ovf,
  input  logic             ie_edge,
  input  logic             reg_sel,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] count,
  output logic             flag_ovf,
  output logic             flag_edge,
  output logic             irq
);
  localparam int H = CNT_W / 2;
  localparam int FLG_W = $bits(flags_t);

  logic pri_level, pri_r, pri_f;
  logic sec_level, sec_r, sec_f;
  logic pri_act, pri_trail, gate_on, sec_act;
  logic inc_lo, inc_hi, load, wr_flags, cnt_access;
  logic wrap_full, wrap_half, hold_hit, set_ovf, set_edge;
  flags_t flags;

  pacc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_pri (
    .clk(clk), .rst_n(rst_n), .pin(pin_pri),
    .level(pri_level), .rise(pri_r), .fall(pri_f));

  pacc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_sec (
    .clk(clk), .rst_n(rst_n), .pin(pin_sec),
    .level(sec_level), .rise(sec_r), .fall(sec_f));

  // event decode
  assign pri_act   = pri_rise ? pri_r : pri_f;
  assign pri_trail = pri_rise ? pri_f : pri_r;
  assign gate_on   = (pri_level == pri_rise);
  assign sec_act   = sec_rise ? sec_r : sec_f;

  assign inc_lo   = acc_enable && (gated_mode ? (gate_on && clk_en) : pri_act);
  assign inc_hi   = acc_enable && split_mode && sec_act;
  assign set_edge = acc_enable && (gated_mode ? pri_trail : pri_act);
  assign set_ovf  = wrap_full || wrap_half || hold_hit;

  // register port decode
  assign cnt_access = (reg_rd || reg_wr) && (reg_sel == REG_COUNT);
  assign load       = reg_wr && (reg_sel == REG_COUNT);
  assign wr_flags   = reg_wr && (reg_sel == REG_FLAGS);

  pacc_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .split(split_mode), .max_hold(max_hold),
    .inc_lo(inc_lo), .inc_hi(inc_hi), .load(load), .load_val(reg_wdata),
    .cnt(count), .wrap_full(wrap_full), .wrap_half(wrap_half), .hold_hit(hold_hit));

  pacc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_ovf(set_ovf), .set_edge(set_edge),
    .wr_flags(wr_flags), .wr_mask(flags_t'(reg_wdata[FLG_W-1:0])),
    .fast_mode(fast_clear), .fast_hit(cnt_access),
    .ie_ovf(ie_ovf), .ie_edge(ie_edge), .flags(flags), .irq(irq));

  assign flag_ovf  = flags.ovf;
  assign flag_edge = flags.edg;
  assign reg_rdata = (reg_sel == REG_COUNT) ? count
                                            : {{(CNT_W-FLG_W){1'b0}}, flags};

  // R4: a synchronised secondary edge in split mode moves the upper half
  assert_sec_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (split_mode && acc_enable && sec_rise && !max_hold && $rose(sec_level) && !load)
      |=> (count[CNT_W-1:H] != $past(count[CNT_W-1:H])));
  // R11: disabled accumulator never raises the edge flag
  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_enable && !flags.edg) |=> !flags.edg);
endmodule

// File: tb/tb_pulse_accum.sv
module tb_pulse_accum;
  localparam time CLK_HALF = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en = 1'b1, pin_pri = 1'b0, pin_sec = 1'b0, acc_enable = 1'b1;
  logic gated_mode = 1'b0, pri_rise = 1'b1, sec_rise = 1'b1, split_mode = 1'b0;
  logic max_hold = 1'b0, fast_clear = 1'b0, ie_ovf = 1'b0, ie_edge = 1'b0;
  logic reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata, count;
  logic flag_ovf, flag_edge, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #CLK_HALF clk = ~clk;

  pulse_accum dut (.*);

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    idle(1);
    reg_wr = 1'b0; reg_sel = 1'b0;
    idle(1);
  endtask

  task automatic clear_flags();
    wr_reg(1'b1, 16'h0003);
  endtask

  task automatic pulse_pri();
    pin_pri = 1'b1; idle(2); pin_pri = 1'b0; idle(4);
  endtask

  task automatic pulse_sec();
    pin_sec = 1'b1; idle(2); pin_sec = 1'b0; idle(4);
  endtask

  task automatic t_reset();
    chk("R9 count after reset", count, 16'h0);
    chk("R9 flags after reset", {flag_edge, flag_ovf}, 2'b00);
    reg_sel = 1'b1; #1;
    chk("R9 flag register read", reg_rdata, 16'h0);
    reg_sel = 1'b0;
    chk("R10 irq after reset", irq, 1'b0);
  endtask

  task automatic t_event();
    pin_pri = 1'b1; idle(2);
    chk("R1 no count before third edge", count, 16'h0);
    idle(1);
    chk("R1 count on third edge", count, 16'h1);
    pin_pri = 1'b0; idle(4);
    pulse_pri(); pulse_pri();
    chk("R1 rising edges counted", count, 16'h3);
    chk("R6 edge flag set in event mode", flag_edge, 1'b1);
    pri_rise = 1'b0;
    pulse_pri(); pulse_pri();
    chk("R1 falling edges counted", count, 16'h5);
    pri_rise = 1'b1;
    wr_reg(1'b0, 16'h1234);
    chk("R11 count load", count, 16'h1234);
    clear_flags();
  endtask

  task automatic t_gated();
    gated_mode = 1'b1; wr_reg(1'b0, 16'h0); clear_flags();
    pin_pri = 1'b1; idle(5);
    chk("R6 no edge flag while gate open", flag_edge, 1'b0);
    idle(5); pin_pri = 1'b0; idle(5);
    chk("R2 gated ticks counted", count, 16'd10);
    chk("R6 trailing edge sets flag", flag_edge, 1'b1);
    clk_en = 1'b0;
    pin_pri = 1'b1; idle(6); pin_pri = 1'b0; idle(5);
    chk("R2 no ticks without clk_en", count, 16'd10);
    clk_en = 1'b1; gated_mode = 1'b0;
    clear_flags();
  endtask

  task automatic t_wrap16();
    wr_reg(1'b0, 16'hFFFF); clear_flags();
    pulse_pri();
    chk("R3 wrap to zero", count, 16'h0);
    chk("R3 overflow flag", flag_ovf, 1'b1);
    clear_flags();
  endtask

  task automatic t_split();
    split_mode = 1'b1; wr_reg(1'b0, 16'hFFFF); clear_flags();
    pulse_pri();
    chk("R4 lower byte wraps alone", count, 16'hFF00);
    chk("R4 lower wrap sets no overflow", flag_ovf, 1'b0);
    pulse_sec();
    chk("R4 upper byte wraps", count, 16'h0000);
    chk("R4 upper wrap sets overflow", flag_ovf, 1'b1);
    pulse_sec();
    chk("R4 secondary edge counted", count, 16'h0100);
    split_mode = 1'b0; clear_flags();
    pulse_sec();
    chk("R4 secondary ignored when cascaded", count, 16'h0100);
    chk("R4 no flags from ignored pin", {flag_edge, flag_ovf}, 2'b00);
  endtask

  task automatic t_hold();
    split_mode = 1'b1; max_hold = 1'b1;
    wr_reg(1'b0, 16'hFF05); clear_flags();
    pulse_sec();
    chk("R5 upper held at FF", count, 16'hFF05);
    chk("R5 extra edge sets overflow", flag_ovf, 1'b1);
    clear_flags();
    pulse_sec();
    chk("R5 still held", count, 16'hFF05);
    chk("R5 overflow again", flag_ovf, 1'b1);
    split_mode = 1'b0; max_hold = 1'b0; clear_flags();
  endtask

  task automatic t_w1c();
    wr_reg(1'b0, 16'hFFFF); pulse_pri();
    chk("R7 both flags set", {flag_edge, flag_ovf}, 2'b11);
    wr_reg(1'b1, 16'h0000);
    chk("R7 zero write keeps flags", {flag_edge, flag_ovf}, 2'b11);
    wr_reg(1'b1, 16'h0001);
    chk("R7 one clears only overflow", {flag_edge, flag_ovf}, 2'b10);
    clear_flags();
    wr_reg(1'b0, 16'hFFFF);
    pin_pri = 1'b1; idle(2);
    reg_sel = 1'b1; reg_wdata = 16'h0003; reg_wr = 1'b1;
    idle(1);
    reg_wr = 1'b0; reg_sel = 1'b0;
    pin_pri = 1'b0; idle(4);
    chk("R7 set wins over clear", {flag_edge, flag_ovf}, 2'b11);
    clear_flags();
  endtask

  task automatic t_fast();
    fast_clear = 1'b1;
    pulse_pri();
    chk("R6 edge flag before fast test", flag_edge, 1'b1);
    wr_reg(1'b1, 16'h0003);
    chk("R8 write ones ignored", flag_edge, 1'b1);
    reg_sel = 1'b0; reg_rd = 1'b1; idle(1); reg_rd = 1'b0; idle(1);
    chk("R8 count read clears", flag_edge, 1'b0);
    pulse_pri();
    wr_reg(1'b0, 16'h00AA);
    chk("R8 count write clears", flag_edge, 1'b0);
    chk("R11 count write loads in fast mode", count, 16'h00AA);
    fast_clear = 1'b0;
  endtask

  task automatic t_irq();
    wr_reg(1'b0, 16'hFFFF); pulse_pri();
    chk("R10 no irq when disabled", irq, 1'b0);
    ie_ovf = 1'b1; #1;
    chk("R10 irq from overflow", irq, 1'b1);
    wr_reg(1'b1, 16'h0001);
    chk("R10 irq drops with overflow", irq, 1'b0);
    ie_edge = 1'b1; #1;
    chk("R10 irq from edge", irq, 1'b1);
    ie_ovf = 1'b0; ie_edge = 1'b0;
    clear_flags();
  endtask

  task automatic t_disable();
    wr_reg(1'b0, 16'h0042);
    acc_enable = 1'b0; split_mode = 1'b1;
    pulse_pri(); pulse_sec();
    chk("R11 disabled count frozen", count, 16'h0042);
    chk("R11 disabled flags quiet", {flag_edge, flag_ovf}, 2'b00);
    acc_enable = 1'b1; split_mode = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_event();
    t_gated();
    t_wrap16();
    t_split();
    t_hold();
    t_w1c();
    t_fast();
    t_irq();
    t_disable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule